// File: doc/BRIEF.md
# SD Multi-Block Read Sequencer

This block runs a read of one or more 512-byte blocks from an SD card that has already been brought up. A start pulse brings in a block address, a block count and two capability flags. The first flag selects block addressing for high-capacity cards. The second says whether the card accepts a pre-declared block count. The sequencer first waits for the data path to leave its inhibited state. It then issues the read commands to a lower-level command engine and programs the transfer geometry of the data path. For each block it waits for a read-ready event, forwards the block's 32-bit words on an output stream, and finishes with a one-cycle completion report.

How the read is carried out depends on the flags. A high-capacity card gets a single read command that carries the block address. For a multi-block read, the card is told the length in advance when it accepts a block count; otherwise an explicit stop command ends the read. A standard-capacity card is read one block at a time, and each block gets its own command with a byte address. Two conditions end a read early with a failure status and a zero byte count: a command error, and a wait that outlasts a run-time cycle limit.

Top module: `sd_mblk_reader`

## Requirements
- R1: After reset, cmd_valid, xfer_cfg_valid, out_valid and rd_done are 0, and rd_bytes is 0.
- R2: A requested block count of 0 is read as exactly one block, issued as a single-block read (index 17), and reports 512 bytes.
- R3: No command is issued while dat_inhibit is 1. If dat_inhibit stays 1 for wait_limit cycles, the read ends with rd_status 2 (timeout), rd_bytes 0 and no command.
- R4: On a high-capacity card (cap_high 1) with cap_setcnt 1 and a count above one, the first command is index 23 with the block count as argument and rd_type 1 (short response).
- R5: On a high-capacity card, xfer_cfg_valid pulses once with xfer_bsize 512 and xfer_bcnt equal to the count. Then exactly one read command follows: index 17 for one block or 18 for several, with blk_addr as argument and rtype 1.
- R6: On a standard-capacity card (cap_high 0), xfer_bcnt is 1. Block i (from 0) is fetched by its own index-17 command with argument (blk_addr + i) × 512.
- R7: For every block the sequencer waits for rd_ready and then forwards exactly 128 words, in order, on out_valid/out_data. A word or rd_ready that arrives outside a block transfer has no effect on the stream.
- R8: On a high-capacity card without set-block-count support, a multi-block read ends with an index-12 command, argument 0 and rtype 2 (response with busy), issued after the last word.
- R9: On success rd_done pulses for one cycle with rd_status 0 and rd_bytes equal to count × 512.
- R10: A cmd_err, or a cmd_done whose response has any bit of RESP_ERR_MASK set (default bits 31:19, 16, 15, 14 and 2), ends the read at once. The report is rd_status 1 and rd_bytes 0, and no further command follows.
- R11: If rd_ready does not arrive within wait_limit cycles of entering the wait, the read ends with rd_status 2 and rd_bytes 0, and not before wait_limit cycles have passed.
- R12: cmd_valid is held, with index and argument stable, until cmd_done or cmd_err. A start pulse during a read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a read |
| blk_addr | input | 32 | First block number of the read |
| blk_cnt | input | CNT_W | Requested blocks (0 means 1) |
| cap_high | input | 1 | Card uses block addressing |
| cap_setcnt | input | 1 | Card accepts a pre-declared block count |
| wait_limit | input | TMR_W | Cycle limit for the inhibit and read-ready waits |
| dat_inhibit | input | 1 | Data path busy; reads may not begin |
| cmd_valid | output | 1 | Command request, held until completion |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 2 | Response type: 1 short, 2 short with busy |
| cmd_done | input | 1 | Command engine completed the request |
| cmd_err | input | 1 | Command engine failed the request |
| cmd_resp | input | 32 | Card status returned with cmd_done |
| xfer_cfg_valid | output | 1 | Pulse: program block size and count |
| xfer_bsize | output | $clog2(BLK_BYTES)+1 | Block size in bytes |
| xfer_bcnt | output | CNT_W | Blocks the data path should expect |
| rd_ready | input | 1 | Data path holds a block ready to read |
| dat_valid | input | 1 | Data word present |
| dat_word | input | WORD_W | Data word |
| out_valid | output | 1 | Output stream word valid |
| out_data | output | WORD_W | Output stream word |
| rd_done | output | 1 | Pulse: read finished |
| rd_status | output | 2 | 0 success, 1 command error, 2 timeout |
| rd_bytes | output | CNT_W+$clog2(BLK_BYTES) | Bytes delivered on success, else 0 |

## Verification
The bench uses the default parameters: 16-bit counts, 512-byte blocks of 128 words, and a 32-bit response error mask. At run time it sets a wait limit of 40 cycles. With these values it can sweep every pairing of the two capability flags against counts from 0 to 4, so the single-block, pre-declared-count, stop-command and per-block byte-address orderings are all compared command by command. The short limit also brings both timeout paths, and aborts at the first and at a later command, within a few hundred cycles.

// File: rtl/sd_rd_pkg.sv
// Package: shared state, operation and code values for the read sequencer.
// Assumes: command indices follow the SD card command numbering.
package sd_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INHIB,
        ST_CFG,
        ST_CMD,
        ST_RDY,
        ST_XFER
    } rd_state_t;

    typedef enum logic [1:0] {
        OP_SETCNT,
        OP_SINGLE,
        OP_MULTI,
        OP_STOP
    } rd_op_t;

    localparam logic [5:0] IDX_STOP   = 6'd12;
    localparam logic [5:0] IDX_SINGLE = 6'd17;
    localparam logic [5:0] IDX_MULTI  = 6'd18;
    localparam logic [5:0] IDX_SETCNT = 6'd23;

    localparam logic [1:0] RT_SHORT = 2'd1;
    localparam logic [1:0] RT_BUSY  = 2'd2;

    localparam logic [1:0] STS_OK     = 2'd0;
    localparam logic [1:0] STS_CMDERR = 2'd1;
    localparam logic [1:0] STS_TMO    = 2'd2;

endpackage

// File: rtl/sd_rd_cmd_sel.sv
// Module: sd_rd_cmd_sel
// Maps the pending operation to command index, argument and response type.
// Assumes: inputs are registered in the parent and stable while a request is up.
module sd_rd_cmd_sel
    import sd_rd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BLK_SHIFT = 9
) (
    input  rd_op_t            op,
    input  logic [31:0]       base_addr,
    input  logic [CNT_W-1:0]  blk_idx,
    input  logic [CNT_W-1:0]  blk_total,
    input  logic              high_cap,
    output logic [5:0]        index,
    output logic [31:0]       arg,
    output logic [1:0]        rtype
);

    logic [31:0] byte_base;

    // Byte address of the current block for standard-capacity cards.
    always_comb begin
        byte_base = (base_addr + 32'(blk_idx)) << BLK_SHIFT;
    end

    // Operation decode into command fields.
    always_comb begin
        index = IDX_SINGLE;
        arg   = 32'd0;
        rtype = RT_SHORT;
        case (op)
            OP_SETCNT: begin
                index = IDX_SETCNT;
                arg   = 32'(blk_total);
            end
            OP_SINGLE: begin
                index = IDX_SINGLE;
                arg   = high_cap ? base_addr : byte_base;
            end
            OP_MULTI: begin
                index = IDX_MULTI;
                arg   = base_addr;
            end
            OP_STOP: begin
                index = IDX_STOP;
                arg   = 32'd0;
                rtype = RT_BUSY;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sd_rd_timer.sv
// Module: sd_rd_timer
// Counts cycles while enabled and flags expiry at the programmed limit.
// Assumes: the count restarts whenever the enable drops.
module sd_rd_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Expiry once the enabled span reaches the limit.
    always_comb begin
        expired = en && (cnt >= limit);
    end

    // Cycle counter, cleared outside a wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sd_rd_beat_cnt.sv
// Module: sd_rd_beat_cnt
// Counts accepted words inside one block and flags the last one.
// Assumes: clr is held outside a block transfer.
module sd_rd_beat_cnt #(
    parameter int WORDS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);

    localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [CW-1:0] cnt;

    // Last word of the block is being accepted.
    always_comb begin
        last = step && (cnt == CW'(WORDS - 1));
    end

    // Word position within the block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sd_mblk_reader.sv
// Module: sd_mblk_reader
// Sequences a multi-block card read over a command engine and a word data
// path, choosing addressing and termination from card capability flags.
// Assumes: the card is initialised; the command engine answers each held
// request with exactly one cmd_done or cmd_err.
module sd_mblk_reader
    import sd_rd_pkg::*;
#(
    parameter int          CNT_W         = 16,
    parameter int          TMR_W         = 16,
    parameter int          WORD_W        = 32,
    parameter int          BLK_BYTES     = 512,
    parameter logic [31:0] RESP_ERR_MASK = 32'hFFF9_C004
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [31:0]                          blk_addr,
    input  logic [CNT_W-1:0]                     blk_cnt,
    input  logic                                 cap_high,
    input  logic                                 cap_setcnt,
    input  logic [TMR_W-1:0]                     wait_limit,
    input  logic                                 dat_inhibit,
    output logic                                 cmd_valid,
    output logic [5:0]                           cmd_index,
    output logic [31:0]                          cmd_arg,
    output logic [1:0]                           cmd_rtype,
    input  logic                                 cmd_done,
    input  logic                                 cmd_err,
    input  logic [31:0]                          cmd_resp,
    output logic                                 xfer_cfg_valid,
    output logic [$clog2(BLK_BYTES):0]           xfer_bsize,
    output logic [CNT_W-1:0]                     xfer_bcnt,
    input  logic                                 rd_ready,
    input  logic                                 dat_valid,
    input  logic [WORD_W-1:0]                    dat_word,
    output logic                                 out_valid,
    output logic [WORD_W-1:0]                    out_data,
    output logic                                 rd_done,
    output logic [1:0]                           rd_status,
    output logic [CNT_W+$clog2(BLK_BYTES)-1:0]   rd_bytes
);

    localparam int BLK_SHIFT = $clog2(BLK_BYTES);
    localparam int WORDS     = BLK_BYTES / (WORD_W / 8);
    localparam int BYTES_W   = CNT_W + BLK_SHIFT;

    rd_state_t        state;
    rd_op_t           op_q;
    logic [31:0]      addr_q;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] idx_next;
    logic             high_q;
    logic             setcnt_q;
    logic             multi;
    logic             use_setcnt;
    logic             use_stop;
    logic             tmr_exp;
    logic             beat_last;
    logic             resp_bad;

    // Read shape derived from the latched request.
    always_comb begin
        multi      = total_q > CNT_W'(1);
        use_setcnt = high_q && multi && setcnt_q;
        use_stop   = high_q && multi && !setcnt_q;
        idx_next   = idx_q + 1'b1;
        resp_bad   = |(cmd_resp & RESP_ERR_MASK);
    end

    // Command fields for the pending operation.
    sd_rd_cmd_sel #(
        .CNT_W     (CNT_W),
        .BLK_SHIFT (BLK_SHIFT)
    ) i_cmd_sel (
        .op        (op_q),
        .base_addr (addr_q),
        .blk_idx   (idx_q),
        .blk_total (total_q),
        .high_cap  (high_q),
        .index     (cmd_index),
        .arg       (cmd_arg),
        .rtype     (cmd_rtype)
    );

    // Watchdog shared by the inhibit wait and the read-ready wait.
    sd_rd_timer #(
        .W (TMR_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      ((state == ST_INHIB) || (state == ST_RDY)),
        .limit   (wait_limit),
        .expired (tmr_exp)
    );

    // Word position inside the current block.
    sd_rd_beat_cnt #(
        .WORDS (WORDS)
    ) i_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_XFER),
        .step  ((state == ST_XFER) && dat_valid),
        .last  (beat_last)
    );

    // Request and geometry outputs taken from state and latched request.
    always_comb begin
        cmd_valid  = (state == ST_CMD);
        xfer_bsize = ($clog2(BLK_BYTES) + 1)'(BLK_BYTES);
        xfer_bcnt  = high_q ? total_q : CNT_W'(1);
    end

    // Sequencing state machine with completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            op_q           <= OP_SINGLE;
            addr_q         <= '0;
            total_q        <= '0;
            idx_q          <= '0;
            high_q         <= 1'b0;
            setcnt_q       <= 1'b0;
            xfer_cfg_valid <= 1'b0;
            rd_done        <= 1'b0;
            rd_status      <= STS_OK;
            rd_bytes       <= '0;
        end else begin
            rd_done        <= 1'b0;
            xfer_cfg_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q   <= blk_addr;
                        total_q  <= (blk_cnt == '0) ? CNT_W'(1) : blk_cnt;
                        idx_q    <= '0;
                        high_q   <= cap_high;
                        setcnt_q <= cap_setcnt;
                        state    <= ST_INHIB;
                    end
                end
                ST_INHIB: begin
                    if (!dat_inhibit) begin
                        if (use_setcnt) begin
                            op_q  <= OP_SETCNT;
                            state <= ST_CMD;
                        end else begin
                            state <= ST_CFG;
                        end
                    end else if (tmr_exp) begin
                        state     <= ST_IDLE;
                        rd_done   <= 1'b1;
                        rd_status <= STS_TMO;
                        rd_bytes  <= '0;
                    end
                end
                ST_CFG: begin
                    xfer_cfg_valid <= 1'b1;
                    op_q           <= (high_q && multi) ? OP_MULTI : OP_SINGLE;
                    state          <= ST_CMD;
                end
                ST_CMD: begin
                    if (cmd_err || (cmd_done && resp_bad)) begin
                        state     <= ST_IDLE;
                        rd_done   <= 1'b1;
                        rd_status <= STS_CMDERR;
                        rd_bytes  <= '0;
                    end else if (cmd_done) begin
                        case (op_q)
                            OP_SETCNT: state <= ST_CFG;
                            OP_STOP: begin
                                state     <= ST_IDLE;
                                rd_done   <= 1'b1;
                                rd_status <= STS_OK;
                                rd_bytes  <= BYTES_W'(total_q) << BLK_SHIFT;
                            end
                            default:   state <= ST_RDY;
                        endcase
                    end
                end
                ST_RDY: begin
                    if (rd_ready) begin
                        state <= ST_XFER;
                    end else if (tmr_exp) begin
                        state     <= ST_IDLE;
                        rd_done   <= 1'b1;
                        rd_status <= STS_TMO;
                        rd_bytes  <= '0;
                    end
                end
                ST_XFER: begin
                    if (beat_last) begin
                        idx_q <= idx_next;
                        if (idx_next == total_q) begin
                            if (use_stop) begin
                                op_q  <= OP_STOP;
                                state <= ST_CMD;
                            end else begin
                                state     <= ST_IDLE;
                                rd_done   <= 1'b1;
                                rd_status <= STS_OK;
                                rd_bytes  <= BYTES_W'(total_q) << BLK_SHIFT;
                            end
                        end else if (!high_q) begin
                            op_q  <= OP_SINGLE;
                            state <= ST_CMD;
                        end else begin
                            state <= ST_RDY;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output stream register; accepts words only inside a block transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state == ST_XFER) && dat_valid;
            if ((state == ST_XFER) && dat_valid) begin
                out_data <= dat_word;
            end
        end
    end

endmodule

// File: rtl/sd_rd_checker.sv
// Module: sd_rd_checker
// Port-level properties of the read sequencer, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module sd_rd_checker #(
    parameter int BLK_BYTES = 512,
    parameter int BYTES_W   = 25
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic [5:0]                 cmd_index,
    input logic [31:0]                cmd_arg,
    input logic [1:0]                 cmd_rtype,
    input logic                       cmd_done,
    input logic                       cmd_err,
    input logic                       xfer_cfg_valid,
    input logic [$clog2(BLK_BYTES):0] xfer_bsize,
    input logic                       rd_done,
    input logic [1:0]                 rd_status,
    input logic [BYTES_W-1:0]         rd_bytes
);

    localparam int BLK_SHIFT = $clog2(BLK_BYTES);

    // R12: a request stays up with stable fields until answered.
    assert_held_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_done && !cmd_err |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg));

    // R5: only the four read-path command indices are ever issued.
    assert_known_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_index == 6'd12) || (cmd_index == 6'd17) ||
                      (cmd_index == 6'd18) || (cmd_index == 6'd23));

    // R8: stop command uses busy response and a zero argument.
    assert_stop_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_index == 6'd12) |-> (cmd_rtype == 2'd2) && (cmd_arg == 32'd0));

    // R4: pre-declared count is never zero and uses a short response.
    assert_setcnt_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_index == 6'd23) |-> (cmd_arg != 32'd0) && (cmd_rtype == 2'd1));

    // R5: geometry pulse always carries the fixed block size.
    assert_block_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cfg_valid |-> (xfer_bsize == ($clog2(BLK_BYTES) + 1)'(BLK_BYTES)));

    // R9: completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R9: a successful report is a non-zero whole number of blocks.
    assert_ok_bytes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && (rd_status == 2'd0) |-> (rd_bytes != '0) && (rd_bytes[BLK_SHIFT-1:0] == '0));

    // R10: a failed report carries zero bytes and no request follows in the same cycle.
    assert_fail_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && (rd_status != 2'd0) |-> (rd_bytes == '0) && !cmd_valid);

endmodule

bind sd_mblk_reader sd_rd_checker #(
    .BLK_BYTES (BLK_BYTES),
    .BYTES_W   (CNT_W + $clog2(BLK_BYTES))
) i_sd_rd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_index      (cmd_index),
    .cmd_arg        (cmd_arg),
    .cmd_rtype      (cmd_rtype),
    .cmd_done       (cmd_done),
    .cmd_err        (cmd_err),
    .xfer_cfg_valid (xfer_cfg_valid),
    .xfer_bsize     (xfer_bsize),
    .rd_done        (rd_done),
    .rd_status      (rd_status),
    .rd_bytes       (rd_bytes)
);

// File: tb/test_sd_mblk_reader.sv
// Bench: models the command engine and data path, sweeps counts and flags,
// and injects command errors, bad responses, stalls and stray traffic.
module test_sd_mblk_reader;

    localparam int CNT_W = 16;
    localparam int TMR_W = 16;
    localparam int LIM   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] blk_addr = '0;
    logic [CNT_W-1:0] blk_cnt = '0;
    logic        cap_high = 1'b0;
    logic        cap_setcnt = 1'b0;
    logic [TMR_W-1:0] wait_limit = TMR_W'(LIM);
    logic        dat_inhibit = 1'b0;
    logic        cmd_valid;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [1:0]  cmd_rtype;
    logic        cmd_done;
    logic        cmd_err;
    logic [31:0] cmd_resp;
    logic        xfer_cfg_valid;
    logic [9:0]  xfer_bsize;
    logic [CNT_W-1:0] xfer_bcnt;
    logic        rd_ready;
    logic        dat_valid;
    logic [31:0] dat_word;
    logic        out_valid;
    logic [31:0] out_data;
    logic        rd_done;
    logic [1:0]  rd_status;
    logic [24:0] rd_bytes;

    sd_mblk_reader i_sd_mblk_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
        .blk_cnt(blk_cnt), .cap_high(cap_high), .cap_setcnt(cap_setcnt),
        .wait_limit(wait_limit), .dat_inhibit(dat_inhibit),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .cmd_rtype(cmd_rtype), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .cmd_resp(cmd_resp), .xfer_cfg_valid(xfer_cfg_valid),
        .xfer_bsize(xfer_bsize), .xfer_bcnt(xfer_bcnt), .rd_ready(rd_ready),
        .dat_valid(dat_valid), .dat_word(dat_word), .out_valid(out_valid),
        .out_data(out_data), .rd_done(rd_done), .rd_status(rd_status),
        .rd_bytes(rd_bytes)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // card model controls and logs
    int err_at = -1;
    int resp_err_at = -1;
    logic [31:0] resp_err_val = '0;
    logic no_ready = 1'b0;
    logic stray = 1'b0;
    int exp_blocks = 1;
    int blk_ctr = 0;
    int log_n = 0;
    logic [5:0]  log_idx [0:15];
    logic [31:0] log_arg [0:15];
    logic [1:0]  log_rt  [0:15];
    int cfg_n = 0;
    logic [CNT_W-1:0] cfg_bcnt = '0;
    logic [9:0] cfg_bsize = '0;
    int out_cnt = 0;
    int out_bad = 0;
    // expectations
    int exp_n = 0;
    logic [5:0]  e_idx [0:15];
    logic [31:0] e_arg [0:15];
    logic [1:0]  e_rt  [0:15];
    logic got_done = 1'b0;
    logic [1:0] got_sts = '0;
    logic [24:0] got_bytes = '0;
    int start_cyc = 0;
    int done_cyc = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    // output and geometry monitor
    always @(negedge clk) begin
        if (xfer_cfg_valid) begin
            cfg_n++;
            cfg_bcnt  = xfer_bcnt;
            cfg_bsize = xfer_bsize;
        end
        if (out_valid) begin
            if (out_data != {8'hA5, 8'(out_cnt / 128), 16'(out_cnt % 128)}) out_bad++;
            out_cnt++;
        end
    end

    // command engine and data path model
    initial begin : card
        int k;
        logic [5:0] cidx;
        cmd_done = 1'b0; cmd_err = 1'b0; cmd_resp = '0;
        rd_ready = 1'b0; dat_valid = 1'b0; dat_word = '0;
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                k = log_n;
                cidx = cmd_index;
                if (log_n < 16) begin
                    log_idx[log_n] = cmd_index;
                    log_arg[log_n] = cmd_arg;
                    log_rt[log_n]  = cmd_rtype;
                end
                log_n++;
                if (stray) begin
                    dat_valid = 1'b1; dat_word = 32'hDEAD_BEEF; rd_ready = 1'b1;
                end
                @(negedge clk);
                dat_valid = 1'b0; rd_ready = 1'b0;
                @(negedge clk);
                if (k == err_at) begin
                    cmd_err = 1'b1;
                end else begin
                    cmd_done = 1'b1;
                    cmd_resp = (k == resp_err_at) ? resp_err_val : 32'h0000_0900;
                end
                @(negedge clk);
                cmd_done = 1'b0; cmd_err = 1'b0;
                if (k != err_at && k != resp_err_at && !no_ready &&
                    (cidx == 6'd17 || cidx == 6'd18)) begin
                    for (int b = 0; b < ((cidx == 6'd18) ? exp_blocks : 1); b++) begin
                        repeat (3) @(negedge clk);
                        rd_ready = 1'b1;
                        @(negedge clk);
                        rd_ready = 1'b0;
                        for (int w = 0; w < 128; w++) begin
                            dat_valid = 1'b1;
                            dat_word = {8'hA5, 8'(blk_ctr), 16'(w)};
                            @(negedge clk);
                        end
                        dat_valid = 1'b0;
                        blk_ctr++;
                    end
                end
            end
        end
    end

    task automatic push_exp(input logic [5:0] i, input logic [31:0] a, input logic [1:0] r);
        e_idx[exp_n] = i; e_arg[exp_n] = a; e_rt[exp_n] = r;
        exp_n++;
    endtask

    // clear logs, build expected command list, issue the start pulse
    task automatic start_read(input logic [31:0] a, input int c, input bit hi, input bit sc);
        int n;
        n = (c == 0) ? 1 : c;
        log_n = 0; cfg_n = 0; out_cnt = 0; out_bad = 0; blk_ctr = 0;
        exp_n = 0; exp_blocks = n; got_done = 1'b0;
        if (hi) begin
            if (n > 1 && sc) push_exp(6'd23, 32'(n), 2'd1);
            push_exp((n > 1) ? 6'd18 : 6'd17, a, 2'd1);
            if (n > 1 && !sc) push_exp(6'd12, 32'd0, 2'd2);
        end else begin
            for (int i = 0; i < n; i++) push_exp(6'd17, (a + 32'(i)) * 32'd512, 2'd1);
        end
        @(negedge clk);
        blk_addr = a; blk_cnt = CNT_W'(c); cap_high = hi; cap_setcnt = sc;
        start = 1'b1;
        start_cyc = cycles;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 20000 && !got_done; t++) begin
            @(negedge clk);
            if (rd_done) begin
                got_done = 1'b1; got_sts = rd_status; got_bytes = rd_bytes;
                done_cyc = cycles;
            end
        end
        repeat (3) @(negedge clk);
        check(got_done, "R9", "completion seen", got_done, 1);
    endtask

    // compare command log, geometry, stream and report for a clean read
    task automatic check_ok(input int c, input bit hi, input bit sc);
        int n;
        bit same;
        string rq;
        n = (c == 0) ? 1 : c;
        rq = !hi ? "R6" : (n > 1 && sc) ? "R4" : (n > 1) ? "R8" : "R5";
        same = (log_n == exp_n);
        for (int i = 0; i < exp_n && i < 16; i++)
            if (log_idx[i] != e_idx[i] || log_arg[i] != e_arg[i] || log_rt[i] != e_rt[i]) same = 0;
        check(same, rq, "command sequence (count shown)", log_n, exp_n);
        check(cfg_n == 1 && cfg_bsize == 10'd512 && cfg_bcnt == (hi ? CNT_W'(n) : CNT_W'(1)),
              hi ? "R5" : "R6", "geometry block count", cfg_bcnt, hi ? n : 1);
        check(out_cnt == 128 * n && out_bad == 0, "R7", "streamed words", out_cnt - out_bad, 128 * n);
        check(got_sts == 2'd0 && got_bytes == 25'(n * 512), (c == 0) ? "R2" : "R9",
              "success byte count", got_bytes, n * 512);
    endtask

    task automatic clear_inject();
        err_at = -1; resp_err_at = -1; no_ready = 1'b0; stray = 1'b0; dat_inhibit = 1'b0;
    endtask

    initial begin
        clear_inject();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!cmd_valid && !xfer_cfg_valid && !out_valid && !rd_done && rd_bytes == '0,
              "R1", "outputs idle under reset", {cmd_valid, xfer_cfg_valid, out_valid, rd_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!cmd_valid && !rd_done && rd_bytes == '0, "R1", "outputs idle after reset",
              {cmd_valid, rd_done}, 0);

        // sweep: all flag pairs, counts 0..4 (R2 R4 R5 R6 R8 R9 R7)
        for (int f = 0; f < 4; f++) begin
            for (int c = 0; c <= 4; c++) begin
                start_read(32'h0000_0100 + 32'(c * 7 + f * 3), c, f[1], f[0]);
                wait_done();
                check_ok(c, f[1], f[0]);
            end
        end

        // R10: engine error on the first command of a pre-declared read
        clear_inject(); err_at = 0;
        start_read(32'h40, 3, 1'b1, 1'b1);
        wait_done();
        repeat (40) @(negedge clk);
        check(got_sts == 2'd1 && got_bytes == '0, "R10", "status on engine error", got_sts, 1);
        check(log_n == 1 && cfg_n == 0 && out_cnt == 0, "R10", "commands after engine error", log_n, 1);

        // R10: error bit 31 in the response of the second block command
        clear_inject(); resp_err_at = 1; resp_err_val = 32'h8000_0000;
        start_read(32'h55, 3, 1'b0, 1'b0);
        wait_done();
        repeat (40) @(negedge clk);
        check(got_sts == 2'd1 && got_bytes == '0, "R10", "status on response bit 31", got_sts, 1);
        check(log_n == 2 && out_cnt == 128, "R10", "commands after response error", log_n, 2);

        // R10: error bit 2 on a single high-capacity read
        clear_inject(); resp_err_at = 0; resp_err_val = 32'h0000_0004;
        start_read(32'h77, 1, 1'b1, 1'b0);
        wait_done();
        check(got_sts == 2'd1 && got_bytes == '0 && out_cnt == 0, "R10", "status on response bit 2", got_sts, 1);

        // R11: read-ready never arrives
        clear_inject(); no_ready = 1'b1;
        start_read(32'h88, 1, 1'b1, 1'b1);
        wait_done();
        check(got_sts == 2'd2 && got_bytes == '0, "R11", "status on ready timeout", got_sts, 2);
        check(done_cyc - start_cyc >= LIM, "R11", "ready timeout not early", done_cyc - start_cyc, LIM);

        // R3: inhibit never clears
        clear_inject(); dat_inhibit = 1'b1;
        start_read(32'h99, 2, 1'b0, 1'b0);
        wait_done();
        check(got_sts == 2'd2 && got_bytes == '0 && log_n == 0, "R3", "inhibit timeout", got_sts, 2);

        // R3: inhibit clears before the limit, read then proceeds
        clear_inject(); dat_inhibit = 1'b1;
        start_read(32'h123, 2, 1'b0, 1'b0);
        repeat (15) @(negedge clk);
        check(log_n == 0 && !got_done, "R3", "no command while inhibited", log_n, 0);
        dat_inhibit = 1'b0;
        wait_done();
        check_ok(2, 1'b0, 1'b0);

        // R12: start during a read is ignored
        clear_inject();
        start_read(32'h200, 2, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        blk_addr = 32'h9999; blk_cnt = 16'd4; cap_high = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_ok(2, 1'b1, 1'b0);
        check(log_n == 2, "R12", "start ignored while busy", log_n, 2);

        // R7: stray words and ready while commands are outstanding
        clear_inject(); stray = 1'b1;
        start_read(32'h300, 2, 1'b1, 1'b1);
        wait_done();
        check_ok(2, 1'b1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule